// File: doc/BRIEF.md
# SPI Slave Serial Front End with Hold

This block is the bit-level front end of a serial memory slave. It watches four pins from the bus master: an active-low select, the serial clock, the serial data input and an active-low pause input. All four are brought into the block's fast system clock through synchronizer flops. Serial clock edges are detected in that domain. Incoming bits are gathered most significant bit first, and each finished byte goes to the command logic with a one-cycle strobe. Bytes that the command logic offers are shifted back out on a serial output, together with an output enable that drives the pad's tri-state buffer.

The pause input lets the master stop a transfer part way through without dropping the select. Entry into the paused state and exit from it both take effect only while the serial clock is low. A pause change made while the clock is high waits for the next low phase. While paused, the output is released, and clock and data activity are ignored. If the select is released during a pause, the whole transfer state is cleared. The block behaves the same whether the master idles its clock low or high.

The serial clock must run at no more than a quarter of the system clock rate.

Top module: `spi_hold_frontend`

## Requirements
- R1: Both clock polarities work with the same sequencing: clock idle low (mode 0) and clock idle high (mode 3). Data in is sampled on rising serial clock edges, most significant bit first.
- R2: After every eighth accepted rising edge, counted from the select falling, `byte_valid` pulses for one system cycle with the assembled byte on `rx_byte`.
- R3: Bytes are sent through a pending buffer written by `tx_load`/`tx_byte`. On an accepted falling edge with the bit count at zero, a pending byte moves into the output shifter: its bit 7 is driven, `miso_oe` rises and `tx_taken` pulses. Each later accepted falling edge inside that byte presents the next lower bit.
- R4: `miso_oe` is low whenever no byte is being shifted: before any byte has been sent, after a byte boundary's falling edge that finds nothing pending, and while deselected.
- R5: `hold_active` rises only when select is low, the pause input is low and the serial clock is low. If the pause input falls while the clock is high, entry waits until the clock goes low. The falling edge that completes such a deferred entry is still acted on.
- R6: `hold_active` falls when the pause input is high and the serial clock is low. If the pause input rises while the clock is high, exit waits until the clock goes low, and the falling edge that completes such a deferred exit is not acted on.
- R7: While `hold_active` is high, `miso_oe` is low and serial clock edges and data-in values have no effect. The bit count and both shift registers keep their values, so the transfer resumes exactly where it stopped.
- R8: When select rises, `frame_end` pulses once and `hold_active` clears. The bit count, shift registers and any pending output byte are also cleared. When select falls, `frame_start` pulses once.
- R9: `tx_load` has no effect while select is high. A byte offered then is never sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_pin | input | 1 | Select from the master, active low, asynchronous |
| sclk_pin | input | 1 | Serial clock from the master, asynchronous |
| mosi_pin | input | 1 | Serial data from the master, asynchronous |
| hold_n_pin | input | 1 | Pause request from the master, active low, asynchronous |
| tx_load | input | 1 | Writes `tx_byte` into the pending output buffer |
| tx_byte | input | 8 | Byte to send next |
| miso_out | output | 1 | Serial data toward the master |
| miso_oe | output | 1 | Output enable for the serial data pad; low means high impedance |
| rx_byte | output | 8 | Last received byte |
| byte_valid | output | 1 | One-cycle strobe marking a new `rx_byte` |
| tx_taken | output | 1 | One-cycle strobe when the pending byte starts shifting |
| frame_start | output | 1 | One-cycle pulse after select falls |
| frame_end | output | 1 | One-cycle pulse after select rises |
| hold_active | output | 1 | High while the transfer is paused |

## Verification
A slipped bit count shows up as wrong bytes. This includes a counter that advances on an edge seen during a pause, or one that is not cleared by a deselect. Every byte after the error in the same frame is affected, so the damage is visible at the next `byte_valid`, within eight serial clocks. A wrongly accepted or dropped falling edge at a deferred pause boundary shifts the response by one bit, which the master's sampled data exposes on its next rising edge. Pause state that is entered at the wrong time, or kept after deselect, appears directly on `hold_active` and `miso_oe` a few system cycles after the pin change.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W);

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [CNT_W-1:0]  bitcnt_t;

  // pin vector ordering used by the synchronizer
  typedef struct packed {
    logic cs_n;
    logic sclk;
    logic mosi;
    logic hold_n;
  } pins_t;

  localparam pins_t PINS_IDLE = '{cs_n: 1'b1, sclk: 1'b0, mosi: 1'b0, hold_n: 1'b1};

  function automatic logic cnt_is_last(bitcnt_t c);
    return c == bitcnt_t'(BYTE_W - 1);
  endfunction

  function automatic bitcnt_t cnt_advance(bitcnt_t c);
    return cnt_is_last(c) ? '0 : bitcnt_t'(c + 1'b1);
  endfunction

  function automatic byte_t shift_in_lsb(byte_t s, logic b);
    return {s[BYTE_W-2:0], b};
  endfunction
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_fe_hold.sv
module spi_fe_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_s,
  input  logic sclk_s,
  input  logic hold_n_s,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_rise,
  output logic cs_fall,
  output logic hold_q
);
  logic sclk_prev, cs_prev, hold_d;

  assign sclk_rise = sclk_s & ~sclk_prev;
  assign sclk_fall = ~sclk_s & sclk_prev;
  assign cs_rise   = cs_n_s & ~cs_prev;
  assign cs_fall   = ~cs_n_s & cs_prev;

  // pause state moves only while the serial clock is low
  always_comb begin
    if (cs_n_s)       hold_d = 1'b0;
    else if (!sclk_s) hold_d = ~hold_n_s;
    else              hold_d = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b0;
      cs_prev   <= 1'b1;
      hold_q    <= 1'b0;
    end else begin
      sclk_prev <= sclk_s;
      cs_prev   <= cs_n_s;
      hold_q    <= hold_d;
    end
  end

  a_r5_enter_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_q) |-> $past(!cs_n_s && !sclk_s && !hold_n_s));
  a_r6_exit_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> $past(cs_n_s || (!sclk_s && hold_n_s)));
  a_r8_desel_clears_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> !hold_q);
endmodule

// File: rtl/spi_fe_engine.sv
module spi_fe_engine
  import spi_fe_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sclk_rise,
  input  logic  sclk_fall,
  input  logic  cs_rise,
  input  logic  cs_fall,
  input  logic  desel,
  input  logic  hold,
  input  logic  mosi_s,
  input  logic  tx_load,
  input  byte_t tx_byte,
  output byte_t rx_byte,
  output logic  byte_valid,
  output logic  tx_taken,
  output logic  miso_out,
  output logic  miso_oe,
  output logic  frame_start,
  output logic  frame_end
);
  bitcnt_t bit_cnt;
  byte_t   rx_sh, tx_sh, pend_b;
  logic    tx_act, pend_v;
  logic    act_rise, act_fall, at_boundary;

  assign act_rise    = sclk_rise & ~hold & ~desel;
  assign act_fall    = sclk_fall & ~hold & ~desel;
  assign at_boundary = (bit_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt     <= '0;
      rx_sh       <= '0;
      rx_byte     <= '0;
      tx_sh       <= '0;
      pend_b      <= '0;
      pend_v      <= 1'b0;
      tx_act      <= 1'b0;
      byte_valid  <= 1'b0;
      tx_taken    <= 1'b0;
      frame_start <= 1'b0;
      frame_end   <= 1'b0;
    end else begin
      byte_valid  <= 1'b0;
      tx_taken    <= 1'b0;
      frame_start <= cs_fall;
      frame_end   <= cs_rise;
      if (desel) begin
        bit_cnt <= '0;
        rx_sh   <= '0;
        tx_sh   <= '0;
        pend_v  <= 1'b0;
        tx_act  <= 1'b0;
      end else begin
        if (act_rise) begin
          rx_sh   <= shift_in_lsb(rx_sh, mosi_s);
          bit_cnt <= cnt_advance(bit_cnt);
          if (cnt_is_last(bit_cnt)) begin
            byte_valid <= 1'b1;
            rx_byte    <= shift_in_lsb(rx_sh, mosi_s);
          end
        end
        if (act_fall) begin
          if (at_boundary) begin
            tx_act   <= pend_v;
            tx_sh    <= pend_b;
            tx_taken <= pend_v;
          end else begin
            tx_sh <= shift_in_lsb(tx_sh, 1'b0);
          end
        end
        if (tx_load) begin
          pend_v <= 1'b1;
          pend_b <= tx_byte;
        end else if (act_fall && at_boundary) begin
          pend_v <= 1'b0;
        end
      end
    end
  end

  assign miso_oe  = tx_act & ~hold & ~desel;
  assign miso_out = tx_act & tx_sh[BYTE_W-1];

  a_r7_frozen_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold && !desel) |-> ($stable(bit_cnt) && $stable(rx_sh) && $stable(tx_sh)));
  a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);
  a_r3_start_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_act) |-> $past(act_fall && at_boundary));
  a_r8_end_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);
  a_r8_cleared_after_desel: assert property (@(posedge clk) disable iff (!rst_n)
    $past(desel) |-> (bit_cnt == '0 && !tx_act && !pend_v));
endmodule

// File: rtl/spi_hold_frontend.sv
module spi_hold_frontend
  import spi_fe_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n_pin,
  input  logic       sclk_pin,
  input  logic       mosi_pin,
  input  logic       hold_n_pin,
  input  logic       tx_load,
  input  logic [7:0] tx_byte,
  output logic       miso_out,
  output logic       miso_oe,
  output logic [7:0] rx_byte,
  output logic       byte_valid,
  output logic       tx_taken,
  output logic       frame_start,
  output logic       frame_end,
  output logic       hold_active
);
  pins_t pins_raw, pins_s;
  logic  sclk_rise, sclk_fall, cs_rise, cs_fall, hold_q;

  assign pins_raw = '{cs_n: cs_n_pin, sclk: sclk_pin, mosi: mosi_pin, hold_n: hold_n_pin};

  spi_fe_sync #(
    .W(4), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
  );

  spi_fe_hold u_hold (
    .clk(clk), .rst_n(rst_n),
    .cs_n_s(pins_s.cs_n), .sclk_s(pins_s.sclk), .hold_n_s(pins_s.hold_n),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_rise(cs_rise), .cs_fall(cs_fall), .hold_q(hold_q)
  );

  spi_fe_engine u_engine (
    .clk(clk), .rst_n(rst_n),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_rise(cs_rise), .cs_fall(cs_fall),
    .desel(pins_s.cs_n), .hold(hold_q), .mosi_s(pins_s.mosi),
    .tx_load(tx_load), .tx_byte(tx_byte),
    .rx_byte(rx_byte), .byte_valid(byte_valid), .tx_taken(tx_taken),
    .miso_out(miso_out), .miso_oe(miso_oe),
    .frame_start(frame_start), .frame_end(frame_end)
  );

  assign hold_active = hold_q;

  a_r4_oe_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n_pin) && $past(cs_n_pin, 2) && $past(cs_n_pin, 3) |-> !miso_oe);
endmodule

// File: tb/spi_hold_frontend_test.sv
module spi_hold_frontend_test;
  localparam int CLK_NS = 10;
  localparam int H = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, hold_n = 1'b1;
  logic tx_load = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic miso_out, miso_oe, byte_valid, tx_taken, frame_start, frame_end, hold_active;
  logic [7:0] rx_byte;

  int checks = 0, errors = 0;
  logic [7:0] rx_log [0:1023];
  int rx_n = 0, fe_n = 0, fs_n = 0, tk_n = 0;

  always #(CLK_NS/2) clk = ~clk;

  spi_hold_frontend uut (
    .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n), .sclk_pin(sclk), .mosi_pin(mosi),
    .hold_n_pin(hold_n), .tx_load(tx_load), .tx_byte(tx_byte),
    .miso_out(miso_out), .miso_oe(miso_oe), .rx_byte(rx_byte), .byte_valid(byte_valid),
    .tx_taken(tx_taken), .frame_start(frame_start), .frame_end(frame_end),
    .hold_active(hold_active)
  );

  always @(negedge clk) begin
    if (byte_valid && rx_n < 1024) begin rx_log[rx_n] = rx_byte; rx_n++; end
    if (frame_end) fe_n++;
    if (frame_start) fs_n++;
    if (tx_taken) tk_n++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected MSB-first serial order, restated from R1/R3
  function automatic logic bit_at(logic [7:0] b, int pos);
    return (b >> pos) & 8'h01;
  endfunction

  task automatic garbage(input int n);
    repeat (n) begin
      sclk = 1'b1; mosi = 1'($urandom); tick(H);
      sclk = 1'b0; mosi = 1'($urandom); tick(H);
    end
  endtask

  task automatic hold_low_phase(input logic restore);
    tick(2); hold_n = 1'b0; tick(6);
    check("R5 entry while clock low", 32'(hold_active), 1);
    check("R7 output released in hold", 32'(miso_oe), 0);
    garbage(3);
    mosi = restore; hold_n = 1'b1; tick(6);
    check("R6 exit while clock low", 32'(hold_active), 0);
  endtask

  task automatic hold_high_phase();
    tick(1); hold_n = 1'b0; tick(6);
    check("R5 entry deferred while clock high", 32'(hold_active), 0);
    sclk = 1'b0; tick(6);
    check("R5 entry at clock low", 32'(hold_active), 1);
    check("R7 output released in hold", 32'(miso_oe), 0);
    garbage(2);
    sclk = 1'b1; tick(H); hold_n = 1'b1; tick(6);
    check("R6 exit deferred while clock high", 32'(hold_active), 1);
    sclk = 1'b0; tick(6);
    check("R6 exit at clock low", 32'(hold_active), 0);
  endtask

  task automatic xfer(input logic [7:0] mo, input int nb, input int hb, input int hph,
                      output logic [7:0] mi, output logic oe_any, output logic oe_all);
    mi = 8'h00; oe_any = 1'b0; oe_all = 1'b1;
    for (int i = 7; i >= 8 - nb; i--) begin
      sclk = 1'b0; mosi = bit_at(mo, i);
      if (hb == i && hph == 0) hold_low_phase(bit_at(mo, i));
      tick(H);
      mi[i] = miso_out;
      oe_any = oe_any | miso_oe; oe_all = oe_all & miso_oe;
      sclk = 1'b1; tick(H);
      if (hb == i && hph == 1) hold_high_phase();
    end
  endtask

  task automatic frame(input logic m3, input logic [7:0] b0, input logic [7:0] b1,
                       input logic [7:0] b2, input logic do_resp, input logic [7:0] resp,
                       input int hbyte, input int hb, input int hph);
    logic [7:0] mi; logic oa, ol; int r0, f0, s0, t0;
    sclk = m3; tick(4);
    r0 = rx_n; f0 = fe_n; s0 = fs_n; t0 = tk_n;
    cs_n = 1'b0; tick(6);
    check("R8 frame_start pulse", 32'(fs_n - s0), 1);
    xfer(b0, 8, (hbyte == 0) ? hb : -1, hph, mi, oa, ol);
    check("R4 no output during command byte", 32'(oa), 0);
    if (do_resp) begin
      tx_byte = resp; tx_load = 1'b1; tick(1); tx_load = 1'b0;
    end
    xfer(b1, 8, (hbyte == 1) ? hb : -1, hph, mi, oa, ol);
    if (do_resp) begin
      check("R3 response bits MSB first", 32'(mi), 32'(resp));
      check("R3 output enabled through response", 32'(ol), 1);
    end else begin
      check("R9 nothing sent", 32'(oa), 0);
    end
    xfer(b2, 8, (hbyte == 2) ? hb : -1, hph, mi, oa, ol);
    check("R4 output released after response", 32'(oa), 0);
    if (!m3) sclk = 1'b0;
    tick(H); cs_n = 1'b1; tick(8);
    check("R2 byte count", 32'(rx_n - r0), 3);
    if (rx_n - r0 == 3) begin
      check(m3 ? "R1 mode3 byte0" : "R1 mode0 byte0", 32'(rx_log[r0]), 32'(b0));
      check("R2 byte1", 32'(rx_log[r0+1]), 32'(b1));
      check("R2 byte2", 32'(rx_log[r0+2]), 32'(b2));
    end
    check("R3 tx_taken count", 32'(tk_n - t0), do_resp ? 1 : 0);
    check("R8 frame_end pulse", 32'(fe_n - f0), 1);
    check("R4 released when deselected", 32'(miso_oe), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] mi; logic oa, ol; int r0, f0;
    void'($urandom(32'd4711));
    tick(3); rst_n = 1'b1; tick(4);
    check("R4 reset oe", 32'(miso_oe), 0);
    check("R5 reset hold", 32'(hold_active), 0);
    check("R2 reset valid", 32'(byte_valid), 0);

    frame(1'b0, 8'h9F, 8'h00, 8'hFF, 1'b1, 8'hA5, 3, 0, 0);
    frame(1'b1, 8'h03, 8'h81, 8'h7E, 1'b1, 8'h5A, 3, 0, 0);
    frame(1'b0, 8'hC3, 8'h12, 8'h34, 1'b1, 8'hE1, 1, 4, 0);
    frame(1'b1, 8'h3C, 8'h56, 8'h78, 1'b1, 8'h96, 1, 5, 1);
    frame(1'b0, 8'h0F, 8'hF0, 8'h55, 1'b1, 8'h69, 1, 3, 1);

    // R9: offer while deselected, never sent
    tx_byte = 8'hFF; tx_load = 1'b1; tick(1); tx_load = 1'b0;
    frame(1'b1, 8'h11, 8'h22, 8'h33, 1'b0, 8'h00, 3, 0, 0);

    // R8: deselect in the middle of a paused byte
    r0 = rx_n; f0 = fe_n; sclk = 1'b0; tick(4);
    cs_n = 1'b0; tick(6);
    xfer(8'hA5, 5, -1, 0, mi, oa, ol);
    sclk = 1'b0; tick(4); hold_n = 1'b0; tick(6);
    check("R5 paused mid byte", 32'(hold_active), 1);
    cs_n = 1'b1; tick(6);
    check("R8 hold cleared by deselect", 32'(hold_active), 0);
    check("R8 frame_end on abort", 32'(fe_n - f0), 1);
    hold_n = 1'b1; tick(4);
    cs_n = 1'b0; tick(6);
    xfer(8'h3C, 8, -1, 0, mi, oa, ol);
    sclk = 1'b0; tick(H); cs_n = 1'b1; tick(8);
    check("R8 fresh count after abort", 32'(rx_n - r0), 1);
    if (rx_n - r0 == 1) check("R8 byte after abort", 32'(rx_log[r0]), 32'h3C);

    for (int k = 0; k < 24; k++) begin
      int hph;
      hph = int'($urandom % 2);
      frame(1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 1'b1, 8'($urandom),
            int'($urandom % 4), 1 + int'($urandom % 7), hph);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule